// File: doc/BRIEF.md
# Idle Wake-Up Interval Timer

This block keeps a free-running counter that advances once per instruction cycle from reset onward. Software picks one of five counter bits. Every change of the picked bit is a timer event. Each event sets a sticky pending flag and, when the enable bit is on, an interrupt request. Software cannot read, load, start or stop the counter. As a result, the first event after an arbitrary moment arrives anywhere from one cycle up to a full window later.

The same events wake the core from its low-power idle state. Software enters idle by setting an idle-request bit. That bit clears itself when a timer event arrives, when the external wake input is asserted, or at reset. A registered idle-active status follows the request one cycle later. A one-cycle exit pulse marks each wake that actually ended idle.

With the default parameters the window lengths are 4096, 8192, 16384, 32768 and 65536 cycles. Moving the window-select field can produce one extra event, because the newly chosen bit may differ from the value last seen on the previously chosen bit.

Top module: `idle_wake_timer`

## Requirements
- R1: The counter increments on every clock after reset, whether or not idle is active. Select values 0, 1, 2, 3 and 4 produce an event every 2^(BASE_TAP+sel) cycles, which is 4096 to 65536 cycles at the default BASE_TAP of 12.
- R2: Select values 5, 6 and 7 behave exactly like select value 4, which is the longest window.
- R3: An event sets `pend_o` at the clock edge that follows the cycle in which the selected counter bit changed. `pend_o` then stays high until a `pend_clr` cycle that has no new event. A clear and an event in the same cycle leave the flag set.
- R4: `irq_o` is high exactly when the pending flag is high and the interrupt enable is set. The enable is written through `ien_wr`/`ien_wdata` and takes effect on the next cycle.
- R5: A cycle with `idle_set` high sets `idle_req_o` on the next cycle. A timer event or `wake_in` clears it on the next cycle. When a wake and `idle_set` arrive in the same cycle, the wake wins.
- R6: Reset sets the window select to 0, and clears the pending flag, the interrupt enable, the idle request, idle-active and the exit pulse.
- R7: `idle_active_o` equals the value `idle_req_o` had one cycle earlier. It therefore falls one cycle after the request clears.
- R8: `idle_exit_o` pulses for one cycle, in the same cycle the request clears, only after a wake (timer event or `wake_in`) found `idle_req_o` high. A wake outside idle gives no pulse.
- R9: An event is any difference between the selected counter bit and the value of the bit selected in the previous cycle. A change of select can therefore raise one event.
- R10: A cycle with `sel_wr` high loads `sel_wdata` into the window select, and `win_sel_o` shows it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the window select |
| sel_wdata | input | SEL_W | New window select value |
| ien_wr | input | 1 | Write strobe for the interrupt enable |
| ien_wdata | input | 1 | New interrupt enable value |
| pend_clr | input | 1 | Clears the pending flag |
| idle_set | input | 1 | Requests entry into idle |
| wake_in | input | 1 | External wake-up source |
| win_sel_o | output | SEL_W | Current window select |
| pend_o | output | 1 | Pending event flag |
| irq_o | output | 1 | Interrupt request |
| idle_req_o | output | 1 | Idle-request bit |
| idle_active_o | output | 1 | Registered idle-active status |
| idle_exit_o | output | 1 | One-cycle idle-exit pulse |

## Verification
The bench builds the block with BASE_TAP set to 2 and keeps five windows, so the windows become 4, 8, 16, 32 and 64 cycles. At that size the bench can measure the exact spacing between events for every select value, including the clamped codes 5 and 7, within a few hundred cycles. The whole counter also wraps many times during the run. Because the windows are short, the bench sees many timer wakes from idle, many collisions between a clear and an event, and many spurious events from select changes at varied counter phases, and a behavioural model checks each of them cycle by cycle.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    typedef struct packed {
        logic ien;
        logic pend;
    } iwt_irq_t;

    typedef struct packed {
        logic req;
        logic act;
        logic exit_p;
    } iwt_idle_t;

endpackage

// File: rtl/iwt_tapcnt.sv
module iwt_tapcnt #(
    parameter int BASE_TAP = 12,
    parameter int NUM_WIN  = 5,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = BASE_TAP + NUM_WIN;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_WIN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tap_prev;
    } tap_st_t;

    tap_st_t          st_d, st_q;
    logic [NUM_WIN-1:0] taps;
    logic [SEL_W-1:0] sel_c;
    logic             tap_now;

    // one candidate bit per window
    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_tap
            assign taps[g] = st_q.cnt[BASE_TAP + g];
        end
    endgenerate

    always_comb begin
        sel_c   = (sel > SEL_MAX) ? SEL_MAX : sel;
        tap_now = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_c == SEL_W'(i)) begin
                tap_now = taps[i];
            end
        end
        // event: selected bit differs from what was seen last cycle
        tick          = tap_now ^ st_q.tap_prev;
        st_d.cnt      = st_q.cnt + CNT_W'(1);
        st_d.tap_prev = tap_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/iwt_regs.sv
module iwt_regs #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    input  logic             pend_clr,
    output logic [SEL_W-1:0] sel,
    output logic             pend,
    output logic             irq
);
    import iwt_pkg::*;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        iwt_irq_t         irq;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.sel = sel_wdata;
        end
        if (ien_wr) begin
            st_d.irq.ien = ien_wdata;
        end
        // a new event outranks a clear in the same cycle
        st_d.irq.pend = tick | (st_q.irq.pend & ~pend_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel  = st_q.sel;
    assign pend = st_q.irq.pend;
    assign irq  = st_q.irq.pend & st_q.irq.ien;
endmodule

// File: rtl/iwt_idle.sv
module iwt_idle (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_set,
    input  logic wake,
    output logic req,
    output logic act,
    output logic exit_p
);
    import iwt_pkg::*;

    iwt_idle_t st_d, st_q;

    always_comb begin
        st_d.exit_p = st_q.req & wake;
        st_d.act    = st_q.req;
        st_d.req    = (st_q.req | idle_set) & ~wake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign act    = st_q.act;
    assign exit_p = st_q.exit_p;
endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer #(
    parameter int BASE_TAP = 12,
    parameter int NUM_WIN  = 5,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    input  logic             pend_clr,
    input  logic             idle_set,
    input  logic             wake_in,
    output logic [SEL_W-1:0] win_sel_o,
    output logic             pend_o,
    output logic             irq_o,
    output logic             idle_req_o,
    output logic             idle_active_o,
    output logic             idle_exit_o
);
    logic tick;
    logic wake_any;

    iwt_tapcnt #(
        .BASE_TAP (BASE_TAP),
        .NUM_WIN  (NUM_WIN),
        .SEL_W    (SEL_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (win_sel_o),
        .tick  (tick)
    );

    iwt_regs #(
        .SEL_W (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .pend_clr  (pend_clr),
        .sel       (win_sel_o),
        .pend      (pend_o),
        .irq       (irq_o)
    );

    assign wake_any = tick | wake_in;

    iwt_idle u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_set (idle_set),
        .wake     (wake_any),
        .req      (idle_req_o),
        .act      (idle_active_o),
        .exit_p   (idle_exit_o)
    );
endmodule

// File: rtl/iwt_checker.sv
module iwt_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_wr,
    input logic [SEL_W-1:0] sel_wdata,
    input logic             pend_clr,
    input logic             wake_in,
    input logic [SEL_W-1:0] win_sel_o,
    input logic             pend_o,
    input logic             irq_o,
    input logic             idle_req_o,
    input logic             idle_active_o,
    input logic             idle_exit_o
);
    a_r10_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (win_sel_o == $past(sel_wdata)));

    a_r3_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !pend_clr) |=> pend_o);

    a_r4_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_o);

    a_r5_wake_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_in |=> !idle_req_o);

    a_r7_active_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_req_o) |=> !idle_active_o);

    a_r8_exit_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exit_o |=> !idle_exit_o);

    a_r8_exit_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exit_o |-> $past(idle_req_o));
endmodule

bind idle_wake_timer iwt_checker #(
    .SEL_W (SEL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_wr        (sel_wr),
    .sel_wdata     (sel_wdata),
    .pend_clr      (pend_clr),
    .wake_in       (wake_in),
    .win_sel_o     (win_sel_o),
    .pend_o        (pend_o),
    .irq_o         (irq_o),
    .idle_req_o    (idle_req_o),
    .idle_active_o (idle_active_o),
    .idle_exit_o   (idle_exit_o)
);

// File: tb/sim_idle_wake_timer.sv
`timescale 1ns/100ps
module sim_idle_wake_timer;
    localparam int B  = 2;
    localparam int NW = 5;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_wr = 1'b0;
    logic [SW-1:0] sel_wdata = '0;
    logic ien_wr = 1'b0;
    logic ien_wdata = 1'b0;
    logic pend_clr = 1'b0;
    logic idle_set = 1'b0;
    logic wake_in = 1'b0;
    logic [SW-1:0] win_sel_o;
    logic pend_o, irq_o, idle_req_o, idle_active_o, idle_exit_o;

    always #2.5 clk = ~clk;

    idle_wake_timer #(.BASE_TAP(B), .NUM_WIN(NW), .SEL_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .pend_clr(pend_clr),
        .idle_set(idle_set), .wake_in(wake_in), .win_sel_o(win_sel_o),
        .pend_o(pend_o), .irq_o(irq_o), .idle_req_o(idle_req_o),
        .idle_active_o(idle_active_o), .idle_exit_o(idle_exit_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference model
    int m_cnt, m_sel, m_win;
    bit m_last, m_bit, m_ev, m_wk;
    bit m_ien, m_pend, m_req, m_act, m_ex;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sel = 0; m_last = 0;
            m_ien = 0; m_pend = 0; m_req = 0; m_act = 0; m_ex = 0;
        end else begin
            cyc++;
            m_win = (m_sel > NW - 1) ? NW - 1 : m_sel;
            m_bit = ((m_cnt >> (B + m_win)) & 1) != 0;
            m_ev  = (m_bit != m_last);
            m_last = m_bit;
            m_cnt = (m_cnt + 1) % (1 << (B + NW));
            m_pend = m_ev || (m_pend && !pend_clr);
            if (sel_wr) m_sel = int'(sel_wdata);
            if (ien_wr) m_ien = ien_wdata;
            m_wk  = m_ev || wake_in;
            m_ex  = m_req && m_wk;
            m_act = m_req;
            m_req = (m_req || idle_set) && !m_wk;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 win_sel", int'(win_sel_o), m_sel);
            chk("R3_R9 pend", int'(pend_o), int'(m_pend));
            chk("R4 irq", int'(irq_o), int'(m_pend && m_ien));
            chk("R5 idle_req", int'(idle_req_o), int'(m_req));
            chk("R7 idle_active", int'(idle_active_o), int'(m_act));
            chk("R8 idle_exit", int'(idle_exit_o), int'(m_ex));
        end
    end

    task automatic report();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_sel(input int v);
        sel_wr = 1'b1; sel_wdata = SW'(v);
        step(1);
        sel_wr = 1'b0;
    endtask

    task automatic write_ien(input bit v);
        ien_wr = 1'b1; ien_wdata = v;
        step(1);
        ien_wr = 1'b0;
    endtask

    // measures the spacing of pend pulses while pend_clr is held high
    task automatic meas(input int s, input string tag);
        int t1, t2, exp, n;
        exp = 1 << (B + ((s > NW - 1) ? NW - 1 : s));
        write_sel(s);
        step(2 * 64);
        t1 = -1; t2 = -1; n = 0;
        while (t2 < 0 && n < 400) begin
            @(negedge clk);
            if (pend_o) begin
                if (t1 < 0) t1 = cyc; else t2 = cyc;
            end
            n++;
        end
        chk(tag, t2 - t1, exp);
        step(1);
    endtask

    initial begin
        int n;
        bit ok;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R6 reset state
        chk("R6 sel", int'(win_sel_o), 0);
        chk("R6 pend", int'(pend_o), 0);
        chk("R6 irq", int'(irq_o), 0);
        chk("R6 idle", int'(idle_req_o | idle_active_o | idle_exit_o), 0);

        pend_clr = 1'b1;
        meas(0, "R1 window sel0");
        meas(1, "R1 window sel1");
        meas(2, "R1 window sel2");
        meas(3, "R1 window sel3");
        meas(4, "R1 window sel4");
        meas(5, "R2 window sel5");
        meas(7, "R2 window sel7");
        pend_clr = 1'b0;

        // R3 sticky pending, R4 gating
        write_sel(0);
        write_ien(1'b1);
        n = 0;
        while (!pend_o && n < 20) begin step(1); n++; end
        ok = 1'b1;
        repeat (20) begin step(1); if (!pend_o) ok = 1'b0; end
        chk("R3 pend sticky", int'(ok), 1);
        chk("R4 irq on", int'(irq_o), 1);
        write_ien(1'b0);
        chk("R4 irq masked", int'(irq_o), 0);
        pend_clr = 1'b1; step(1); pend_clr = 1'b0;

        // R5 R7 R8 timer wake from idle
        idle_set = 1'b1; step(1); idle_set = 1'b0;
        n = 0;
        while (idle_req_o && n < 20) begin step(1); n++; end
        chk("R5 timer wake bound", int'(n <= 4), 1);
        chk("R8 exit pulse", int'(idle_exit_o), 1);
        chk("R7 active lag", int'(idle_active_o), 1);
        step(1);
        chk("R7 active off", int'(idle_active_o), 0);
        chk("R8 exit single", int'(idle_exit_o), 0);

        // R5 external wake
        write_sel(4);
        idle_set = 1'b1; step(1); idle_set = 1'b0;
        step(2);
        wake_in = 1'b1; step(1); wake_in = 1'b0;
        chk("R5 wake_in ends idle", int'(idle_req_o), 0);
        step(3);
        // R8 wake outside idle
        wake_in = 1'b1; step(1); wake_in = 1'b0;
        chk("R8 no exit outside idle", int'(idle_exit_o), 0);
        // R5 same-cycle set and wake
        idle_set = 1'b1; wake_in = 1'b1; step(1);
        idle_set = 1'b0; wake_in = 1'b0;
        chk("R5 wake wins", int'(idle_req_o), 0);

        // R9 select changes at varied phases, compared by the model
        write_ien(1'b1);
        for (int i = 0; i < 60; i++) begin
            write_sel((i * 3) % 8);
            step(3 + (i % 11));
            if (i % 4 == 0) begin pend_clr = 1'b1; step(1); pend_clr = 1'b0; end
            if (i % 5 == 0) begin idle_set = 1'b1; step(1); idle_set = 1'b0; end
        end
        step(10);
        report();
    end
endmodule